// File: doc/BRIEF.md
# DS3 Idle Signal Detector

This block watches a DS3 receive stream that an upstream framer has already aligned and tagged bit by bit. Each bit arrives with a class tag: payload, C-bit, X-bit, or F/M/P overhead. A C-bit also carries a flag that marks subframe 3, and an overhead bit carries a flag that says its value is valid. For every frame the block counts deviations from the idle signal. The idle payload is the repeating pattern 1100. The subframe-3 C-bits must be 0, the X-bits must be 1, and the framing overhead must be valid. The block raises an idle status after two clean frames in a row and drops it after two dirty frames in a row. An out-of-frame indication drops the status at once.

A frame strobe closes each frame and triggers the evaluation. The status bit comes with one-cycle start and end pulses that an interrupt controller can collect. When the status is active and the all-ones enable is set, the receive data output is forced to 1. Otherwise the data passes straight through.

Top module: `ds3_idle_det`

## Requirements
- R1: After reset, idle_o, idle_start_o and idle_end_o are 0, and rx_data_o equals rx_data_i.
- R2: Class codes on bit_cls_i are 0 = payload, 1 = C-bit, 2 = X-bit and 3 = F/M/P overhead. A bit counts only while bit_en_i is 1 and frame_i is 0.
- R3: The phase of the payload pattern 1100 is chosen from the first four payload bits of each frame. The block picks the phase with the fewest mismatches, and the lowest phase wins a tie. That mismatch count is added to the frame's deviations. After the first four bits, each payload bit that differs from the locked pattern adds one deviation.
- R4: A C-bit with c_sf3_i = 1 adds a deviation when it is 1. A C-bit with c_sf3_i = 0 never adds a deviation.
- R5: An X-bit that is 0 adds a deviation. An overhead bit with ovh_ok_i = 0 adds a deviation.
- R6: A frame is good when it has 10 or fewer deviations. When idle_o is 0, it rises in the cycle after the second consecutive good frame strobe. oof_i must be 0 at both strobes. A bad frame, or oof_i = 1 in any cycle, restarts the run.
- R7: When idle_o is 1, it falls in the cycle after the second consecutive frame with 11 or more deviations. A good frame between two bad ones restarts the count.
- R8: When idle_o is 1, oof_i = 1 in any cycle clears idle_o in the next cycle.
- R9: idle_start_o is a one-cycle pulse in the first cycle that idle_o is 1. idle_end_o is a one-cycle pulse in the first cycle that idle_o is 0 again.
- R10: rx_data_o is 1 while idle_o and all1_en_i are both 1. Otherwise rx_data_o equals rx_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | A receive bit is present this cycle |
| rx_data_i | input | 1 | Receive bit |
| bit_cls_i | input | 2 | Class of the bit (0 payload, 1 C, 2 X, 3 F/M/P) |
| c_sf3_i | input | 1 | C-bit belongs to subframe 3 |
| ovh_ok_i | input | 1 | F/M/P bit holds its valid value |
| frame_i | input | 1 | Frame strobe that closes the frame; the bit inputs are ignored in this cycle |
| oof_i | input | 1 | Out-of-frame indication |
| all1_en_i | input | 1 | Enables all-ones substitution during idle |
| rx_data_o | output | 1 | Receive data, substituted with 1 during idle when enabled |
| idle_o | output | 1 | Idle status |
| idle_start_o | output | 1 | Pulse when idle is declared |
| idle_end_o | output | 1 | Pulse when idle is cleared |

## Verification
A wrong phase lock or a wrong deviation count stays inside the frame. It only shows at the ports when a frame strobe pushes a frame across the 10/11 boundary, so frames are built to land exactly on 10 and 11 deviations. A stale run counter shows one frame late, as a status change one strobe too early or too late. Because the pulses and the status come from the same registered decision, a mismatch between them is visible in the cycle right after the strobe or after the out-of-frame cycle.

// File: rtl/ds3_idle_pkg.sv
package ds3_idle_pkg;
  typedef enum logic [1:0] {
    CLS_PAY  = 2'd0,
    CLS_CBIT = 2'd1,
    CLS_XBIT = 2'd2,
    CLS_OVH  = 2'd3
  } bit_cls_e;
endpackage

// File: rtl/ds3_idle_phase.sv
module ds3_idle_phase (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pay_vld_i,
  input  logic       bit_i,
  input  logic       frame_i,
  output logic [2:0] inc_o
);
  localparam int NPH = 4;

  logic [1:0] lrn_cnt_q;
  logic       locked_q;
  logic [2:0] mm_q [NPH];
  logic [2:0] mm_d [NPH];
  logic [1:0] phase_q, pos_q;
  logic [2:0] best_mm;
  logic [1:0] best_ph;
  logic [1:0] lidx;

  // per-phase mismatch during learning; pattern index i expects ~i[1]
  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [1:0] idx;
    assign idx     = lrn_cnt_q + 2'(p);
    assign mm_d[p] = mm_q[p] + {2'b00, bit_i == idx[1]};
  end

  always_comb begin
    best_mm = mm_d[0];
    best_ph = 2'd0;
    for (int p = 1; p < NPH; p++) begin
      if (mm_d[p] < best_mm) begin
        best_mm = mm_d[p];
        best_ph = 2'(p);
      end
    end
  end

  assign lidx = pos_q + phase_q;

  always_comb begin
    inc_o = 3'd0;
    if (pay_vld_i) begin
      if (locked_q)                inc_o = {2'b00, bit_i == lidx[1]};
      else if (lrn_cnt_q == 2'd3)  inc_o = best_mm;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrn_cnt_q <= '0;
      locked_q  <= 1'b0;
      phase_q   <= '0;
      pos_q     <= '0;
      for (int p = 0; p < NPH; p++) mm_q[p] <= '0;
    end else if (frame_i) begin
      lrn_cnt_q <= '0;
      locked_q  <= 1'b0;
      pos_q     <= '0;
      for (int p = 0; p < NPH; p++) mm_q[p] <= '0;
    end else if (pay_vld_i) begin
      if (locked_q) begin
        pos_q <= pos_q + 2'd1;
      end else begin
        for (int p = 0; p < NPH; p++) mm_q[p] <= mm_d[p];
        lrn_cnt_q <= lrn_cnt_q + 2'd1;
        if (lrn_cnt_q == 2'd3) begin
          locked_q <= 1'b1;
          phase_q  <= best_ph;
          pos_q    <= '0;
        end
      end
    end
  end

  // R3
  lock_after_four_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> ($past(lrn_cnt_q) == 2'd3) && $past(pay_vld_i));
endmodule

// File: rtl/ds3_idle_devcnt.sv
module ds3_idle_devcnt #(
  parameter int MAX_DEV = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic [2:0] pay_inc_i,
  input  logic       ovh_dev_i,
  output logic       frame_ok_o
);
  localparam int DEV_W = $clog2(MAX_DEV + 2);
  localparam logic [DEV_W:0] SAT = (DEV_W+1)'(MAX_DEV + 1);

  logic [DEV_W-1:0] dev_q;
  logic [DEV_W:0]   sum;

  assign sum = {1'b0, dev_q} + (DEV_W+1)'(pay_inc_i) + (DEV_W+1)'(ovh_dev_i);
  assign frame_ok_o = ({1'b0, dev_q} <= (DEV_W+1)'(MAX_DEV));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dev_q <= '0;
    else if (frame_i) dev_q <= '0;
    else              dev_q <= (sum > SAT) ? SAT[DEV_W-1:0] : sum[DEV_W-1:0];
  end

  // R3
  dev_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_i) |-> dev_q >= $past(dev_q));
endmodule

// File: rtl/ds3_idle_hyst.sv
module ds3_idle_hyst #(
  parameter int DECL_N = 2,
  parameter int CLR_N  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic frame_ok_i,
  input  logic oof_i,
  output logic idle_o,
  output logic start_o,
  output logic end_o
);
  localparam int MAXN  = (DECL_N > CLR_N) ? DECL_N : CLR_N;
  localparam int RUN_W = $clog2(MAXN + 1);

  logic [RUN_W-1:0] good_q, bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_o  <= 1'b0;
      start_o <= 1'b0;
      end_o   <= 1'b0;
      good_q  <= '0;
      bad_q   <= '0;
    end else begin
      start_o <= 1'b0;
      end_o   <= 1'b0;
      if (idle_o) begin
        if (oof_i) begin
          idle_o <= 1'b0;
          end_o  <= 1'b1;
          bad_q  <= '0;
          good_q <= '0;
        end else if (frame_i) begin
          if (frame_ok_i) begin
            bad_q <= '0;
          end else if (bad_q == RUN_W'(CLR_N - 1)) begin
            idle_o <= 1'b0;
            end_o  <= 1'b1;
            bad_q  <= '0;
          end else begin
            bad_q <= bad_q + 1'b1;
          end
        end
      end else begin
        if (oof_i) begin
          good_q <= '0;
        end else if (frame_i) begin
          if (!frame_ok_i) begin
            good_q <= '0;
          end else if (good_q == RUN_W'(DECL_N - 1)) begin
            idle_o  <= 1'b1;
            start_o <= 1'b1;
            good_q  <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
      end
    end
  end

  // R9
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, end_o}));
  // R9
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R6
  declare_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> $past(frame_i) && !$past(oof_i) && $past(frame_ok_i));
  // R8
  oof_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && oof_i |=> !idle_o && end_o);
endmodule

// File: rtl/ds3_idle_det.sv
module ds3_idle_det
  import ds3_idle_pkg::*;
#(
  parameter int MAX_DEV     = 10,
  parameter int DECL_FRAMES = 2,
  parameter int CLR_FRAMES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       rx_data_i,
  input  logic [1:0] bit_cls_i,
  input  logic       c_sf3_i,
  input  logic       ovh_ok_i,
  input  logic       frame_i,
  input  logic       oof_i,
  input  logic       all1_en_i,
  output logic       rx_data_o,
  output logic       idle_o,
  output logic       idle_start_o,
  output logic       idle_end_o
);
  bit_cls_e   cls;
  logic       bit_vld, pay_vld, ovh_dev, frame_ok;
  logic [2:0] pay_inc;

  assign cls     = bit_cls_e'(bit_cls_i);
  assign bit_vld = bit_en_i & ~frame_i;
  assign pay_vld = bit_vld & (cls == CLS_PAY);

  always_comb begin
    ovh_dev = 1'b0;
    if (bit_vld) begin
      unique case (cls)
        CLS_CBIT: ovh_dev = c_sf3_i & rx_data_i;
        CLS_XBIT: ovh_dev = ~rx_data_i;
        CLS_OVH:  ovh_dev = ~ovh_ok_i;
        default:  ovh_dev = 1'b0;
      endcase
    end
  end

  ds3_idle_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pay_vld_i(pay_vld),
    .bit_i    (rx_data_i),
    .frame_i  (frame_i),
    .inc_o    (pay_inc)
  );

  ds3_idle_devcnt #(.MAX_DEV(MAX_DEV)) u_devcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame_i),
    .pay_inc_i (pay_inc),
    .ovh_dev_i (ovh_dev),
    .frame_ok_o(frame_ok)
  );

  ds3_idle_hyst #(.DECL_N(DECL_FRAMES), .CLR_N(CLR_FRAMES)) u_hyst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame_i),
    .frame_ok_i(frame_ok),
    .oof_i     (oof_i),
    .idle_o    (idle_o),
    .start_o   (idle_start_o),
    .end_o     (idle_end_o)
  );

  assign rx_data_o = (idle_o & all1_en_i) | rx_data_i;

  // R4
  unsf3_c_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld && (cls == CLS_CBIT) && !c_sf3_i |-> !ovh_dev);
endmodule

// File: tb/sim_ds3_idle_det.sv
module sim_ds3_idle_det;
  localparam int CLK_PERIOD = 10;
  localparam int PAY_N      = 48;
  localparam int NVEC       = 12;

  // {ph[21:20], lrn[19:18], pay[17:12], cb3[11:10], x[9:8], ovh[7:6], cbo[5:4], oof, idle, start, end}
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 6'd0,  2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd2, 6'd2,  2'd2, 2'd2, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd0, 2'd1, 6'd10, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd0, 6'd0,  2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd0, 6'd8,  2'd1, 2'd1, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd0, 6'd30, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'd2, 2'd0, 6'd0,  2'd0, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, 2'd0, 6'd11, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, 2'd0, 6'd0,  2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd3, 2'd0, 6'd0,  2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd3, 2'd0, 6'd0,  2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd0, 6'd0,  2'd0, 2'd0, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, rx_data = 1'b0, c_sf3 = 1'b0, ovh_ok = 1'b1;
  logic frame = 1'b0, oof = 1'b0, all1_en = 1'b0;
  logic [1:0] cls = 2'd0;
  logic rx_out, idle, start_p, end_p;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ds3_idle_det u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .rx_data_i(rx_data),
    .bit_cls_i(cls), .c_sf3_i(c_sf3), .ovh_ok_i(ovh_ok), .frame_i(frame),
    .oof_i(oof), .all1_en_i(all1_en), .rx_data_o(rx_out), .idle_o(idle),
    .idle_start_o(start_p), .idle_end_o(end_p)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic [1:0] c, input logic d, input logic sf3, input logic ok);
    @(negedge clk);
    bit_en = 1'b1; cls = c; rx_data = d; c_sf3 = sf3; ovh_ok = ok;
  endtask

  task automatic send_frame(input int ph, input int lrn, input int pay, input int cb3,
                            input int xe, input int ovh, input int cbo);
    for (int i = 0; i < 2; i++) put_bit(2'd2, !(i < xe), 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) put_bit(2'd1, (i < cb3), 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) put_bit(2'd1, (i < cbo), 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) put_bit(2'd3, 1'b1, 1'b0, !(i < ovh));
    for (int k = 0; k < PAY_N; k++) begin
      logic d;
      d = !(((k + ph) >> 1) & 1);
      if (lrn >= 1 && k == 3) d = !d;
      if (lrn >= 2 && k == 2) d = !d;
      if (k >= 4 && k < 4 + pay) d = !d;
      put_bit(2'd0, d, 1'b0, 1'b1);
    end
    @(negedge clk);
    bit_en = 1'b0; rx_data = 1'b0; frame = 1'b1;
    @(negedge clk);
    frame = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 idle", idle, 1'b0);
    chk("R1 start", start_p, 1'b0);
    chk("R1 end", end_p, 1'b0);
    rx_data = 1'b1; #1;
    chk("R1 pass", rx_out, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R9 through frame vectors
    for (int v = 0; v < NVEC; v++) begin
      logic [21:0] e;
      e = VEC[v];
      oof = e[3];
      send_frame(int'(e[21:20]), int'(e[19:18]), int'(e[17:12]), int'(e[11:10]),
                 int'(e[9:8]), int'(e[7:6]), int'(e[5:4]));
      oof = 1'b0;
      chk($sformatf("R6/R7 idle vec%0d", v), idle, e[2]);
      chk($sformatf("R9 start vec%0d", v), start_p, e[1]);
      chk($sformatf("R9 end vec%0d", v), end_p, e[0]);
    end

    // R9 pulse lasts one cycle
    @(negedge clk);
    chk("R9 start drops", start_p, 1'b0);
    chk("R9 idle holds", idle, 1'b1);

    // R10 substitution
    all1_en = 1'b1; rx_data = 1'b0; #1;
    chk("R10 all ones", rx_out, 1'b1);
    all1_en = 1'b0; #1;
    chk("R10 disabled", rx_out, 1'b0);

    // R8 immediate clear by OOF
    @(negedge clk); oof = 1'b1;
    @(negedge clk); oof = 1'b0;
    chk("R8 idle cleared", idle, 1'b0);
    chk("R8 end pulse", end_p, 1'b1);
    @(negedge clk);
    chk("R9 end drops", end_p, 1'b0);
    all1_en = 1'b1; rx_data = 1'b0; #1;
    chk("R10 no idle", rx_out, 1'b0);
    all1_en = 1'b0;

    finish_run();
  end
endmodule